// File: doc/BRIEF.md
# Board Control Unit with Cycle-Count Interrupt

This block extends a serially loaded cartridge bank mapper for a timed competition board. The first character register of the base mapper is read here as a board control register, which does two jobs. It gates a free-running CPU-cycle timer that raises an interrupt when a time limit set by four DIP switches runs out. It also chooses between two program banking schemes: one coarse 32 KiB outer bank covering the whole upper half of the CPU space, or ordinary 16 KiB banking confined to the upper eight 16 KiB banks.

The serial shift loader is not part of this block. The block receives the register values the loader has already committed, a one-cycle strobe each time a new board value is committed, a one-cycle pulse per CPU cycle, and the static DIP setting. It drives the two 16 KiB program bank numbers, for the lower and upper program windows, and a level-active interrupt request. Character memory on this board is one 8 KiB RAM, so the character bank output is always zero.

The timer is `CNT_W` bits wide (30 by default). The top five counter bits decide when it fires. The DIP value is ORed into the four bits just below the most significant bit.

Top module: `cycle_timer_mapper`

## Requirements
- R1: After reset `irq` is low and the cycle counter is zero. With a dip of 0xE, the first interrupt after reset then comes on the 544th enabled tick (for `CNT_W`=10).
- R2: The counter advances by one on each clock where `tick` is 1 and bit 4 of `boardVal` is 0. It holds its value when `tick` is 0 or bit 4 is 1, even if no commit takes place.
- R3: An enabled tick that brings the counter to a value n with (n OR (dip << (CNT_W-5))) >= 31 << (CNT_W-5) sets `irq` to 1 and resets the counter to zero. With the default width this threshold is 0x3E000000 and the dip sits at bit 25.
- R4: Once set, `irq` stays 1 through further ticks and idle cycles until it is acknowledged (R5) or the block is reset.
- R5: A cycle with `boardCommit`=1 and `boardVal[4]`=1 clears both `irq` and the counter on that clock edge. This takes priority over a tick in the same cycle.
- R6: When `boardVal[3]`=0, the program space is one 32 KiB bank o = `boardVal[2:1]`: `bankLo` = 2o and `bankHi` = 2o+1, whatever `prgMode` and `prgSel` hold.
- R7: When `boardVal[3]`=1 and `prgMode` is 0 or 1 (32 KiB switching), `bankLo` = 8 OR (`prgSel` AND 6) and `bankHi` = `bankLo` + 1.
- R8: When `boardVal[3]`=1 and `prgMode`=2, `bankLo` = 8 and `bankHi` = 8 OR (`prgSel` AND 7).
- R9: When `boardVal[3]`=1 and `prgMode`=3, `bankLo` = 8 OR (`prgSel` AND 7) and `bankHi` = 15.
- R10: `chrBank` is zero for every combination of inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One pulse per CPU cycle |
| dip | input | 4 | Static time-limit DIP setting |
| boardVal | input | 5 | Committed board control register value |
| boardCommit | input | 1 | Strobe: `boardVal` was committed this cycle |
| prgMode | input | 2 | Committed program banking mode (0/1 pair, 2 low fixed, 3 high fixed) |
| prgSel | input | 4 | Committed program bank register |
| bankLo | output | 4 | 16 KiB bank number for the lower program window |
| bankHi | output | 4 | 16 KiB bank number for the upper program window |
| chrBank | output | CHR_W | Character bank number, always zero |
| irq | output | 1 | Interrupt request, level active high |

## Verification
The checker assumes several things about the inputs. `tick` is at most one pulse per clock. `boardVal` is stable in the cycle that `boardCommit` marks. `dip` does not change while the timer is running. Under these assumptions an interrupt can only rise after an enabled tick, and it falls only on an acknowledging commit or reset. The stimulus changes `dip` only after the timer has been cleared by a commit with bit 4 set. It holds `boardVal` steady around every commit strobe. It drives `tick` for one cycle at a time from the falling edge. The test build narrows the counter to 10 bits, so that each of the sixteen DIP settings reaches its threshold within about a thousand cycles.

// File: rtl/cycle_timer_pkg.sv
package cycle_timer_pkg;

  localparam int BANK_W = 4;
  localparam int BOARD_W = 5;
  localparam int DIP_W = 4;
  localparam int TOP_BITS = DIP_W + 1;

  // Strobes from control to timer datapath
  typedef struct packed {
    logic advance;
    logic clear;
  } timerStrobes_t;

endpackage

// File: rtl/cycle_timer_ctrl.sv
module cycle_timer_ctrl
  import cycle_timer_pkg::*;
(
  input  logic                 tick,
  input  logic [BOARD_W-1:0]   boardVal,
  input  logic                 boardCommit,
  input  logic [1:0]           prgMode,
  input  logic [BANK_W-1:0]    prgSel,
  output timerStrobes_t        strobes,
  output logic [BANK_W-1:0]    bankLo,
  output logic [BANK_W-1:0]    bankHi
);

  localparam int SUB_W = BANK_W - 1;

  logic timerHold;
  logic innerBanking;
  logic [1:0] outerSel;
  logic [SUB_W-1:0] innerSel;

  assign timerHold    = boardVal[4];
  assign innerBanking = boardVal[3];
  assign outerSel     = boardVal[2:1];
  assign innerSel     = prgSel[SUB_W-1:0];

  always_comb begin
    strobes.clear   = boardCommit & timerHold;
    strobes.advance = tick & ~timerHold & ~strobes.clear;
  end

  always_comb begin
    if (!innerBanking) begin
      bankLo = {1'b0, outerSel, 1'b0};
      bankHi = {1'b0, outerSel, 1'b1};
    end else begin
      unique case (prgMode)
        2'd2: begin
          bankLo = {1'b1, {SUB_W{1'b0}}};
          bankHi = {1'b1, innerSel};
        end
        2'd3: begin
          bankLo = {1'b1, innerSel};
          bankHi = {1'b1, {SUB_W{1'b1}}};
        end
        default: begin
          bankLo = {1'b1, innerSel[SUB_W-1:1], 1'b0};
          bankHi = {1'b1, innerSel[SUB_W-1:1], 1'b1};
        end
      endcase
    end
  end

endmodule

// File: rtl/cycle_timer_path.sv
module cycle_timer_path
  import cycle_timer_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  timerStrobes_t     strobes,
  input  logic [DIP_W-1:0]  dip,
  output logic              irq
);

  localparam int SHIFT = CNT_W - TOP_BITS;

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] nextCount;
  logic [TOP_BITS-1:0] topField;
  logic limitHit;

  // Threshold is all ones in the top field and zeros below it, so
  // "greater or equal" reduces to an AND over the top field.
  assign nextCount = count + CNT_W'(1);
  assign topField  = nextCount[CNT_W-1:SHIFT] | {1'b0, dip};
  assign limitHit  = &topField;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (strobes.clear) begin
      count <= '0;
      irq   <= 1'b0;
    end else if (strobes.advance) begin
      if (limitHit) begin
        count <= '0;
        irq   <= 1'b1;
      end else begin
        count <= nextCount;
      end
    end
  end

endmodule

// File: rtl/cycle_timer_mapper.sv
module cycle_timer_mapper
  import cycle_timer_pkg::*;
#(
  parameter int CNT_W = 30,
  parameter int CHR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [3:0]        dip,
  input  logic [4:0]        boardVal,
  input  logic              boardCommit,
  input  logic [1:0]        prgMode,
  input  logic [3:0]        prgSel,
  output logic [3:0]        bankLo,
  output logic [3:0]        bankHi,
  output logic [CHR_W-1:0]  chrBank,
  output logic              irq
);

  timerStrobes_t strobes;

  cycle_timer_ctrl ctrl (
    .tick(tick),
    .boardVal(boardVal),
    .boardCommit(boardCommit),
    .prgMode(prgMode),
    .prgSel(prgSel),
    .strobes(strobes),
    .bankLo(bankLo),
    .bankHi(bankHi)
  );

  cycle_timer_path #(.CNT_W(CNT_W)) path (
    .clk(clk),
    .rst(rst),
    .strobes(strobes),
    .dip(dip),
    .irq(irq)
  );

  // Single 8 KiB character RAM
  assign chrBank = '0;

endmodule

// File: rtl/cycle_timer_mapper_chk.sv
module cycle_timer_mapper_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [4:0] boardVal,
  input logic       boardCommit,
  input logic [3:0] bankLo,
  input logic [3:0] bankHi,
  input logic       irq
);

  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq);

  assert_rise_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(tick) && !$past(boardVal[4])));

  assert_irq_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (irq && !(boardCommit && boardVal[4])) |=> irq);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (boardCommit && boardVal[4]) |=> !irq);

  assert_outer_pair_R6: assert property (@(posedge clk) disable iff (rst)
    !boardVal[3] |-> (!bankLo[0] && !bankLo[3] && bankHi == bankLo + 4'd1));

  assert_inner_upper_R7: assert property (@(posedge clk) disable iff (rst)
    boardVal[3] |-> (bankLo[3] && bankHi[3]));

endmodule

bind cycle_timer_mapper cycle_timer_mapper_chk chk (
  .clk(clk),
  .rst(rst),
  .tick(tick),
  .boardVal(boardVal),
  .boardCommit(boardCommit),
  .bankLo(bankLo),
  .bankHi(bankHi),
  .irq(irq)
);

// File: tb/cycle_timer_mapper_test.sv
`timescale 1ns/1ps
module cycle_timer_mapper_test;

  localparam int CNT_W = 10;
  localparam int CHR_W = 5;
  localparam int SHIFT = CNT_W - 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [3:0] dip = 4'hE;
  logic [4:0] boardVal = 5'd0;
  logic boardCommit = 1'b0;
  logic [1:0] prgMode = 2'd0;
  logic [3:0] prgSel = 4'd0;
  logic [3:0] bankLo, bankHi;
  logic [CHR_W-1:0] chrBank;
  logic irq;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cycle_timer_mapper #(.CNT_W(CNT_W), .CHR_W(CHR_W)) uut (
    .clk(clk), .rst(rst), .tick(tick), .dip(dip),
    .boardVal(boardVal), .boardCommit(boardCommit),
    .prgMode(prgMode), .prgSel(prgSel),
    .bankLo(bankLo), .bankHi(bankHi), .chrBank(chrBank), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int firstHit(input int d);
    for (int n = 1; n < (1 << CNT_W); n++)
      if ((n | (d << SHIFT)) >= (31 << SHIFT)) return n;
    return -1;
  endfunction

  // n enabled tick pulses; returns at the falling edge after the last one
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
    end
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic commit(input logic [4:0] v, input logic withTick);
    @(negedge clk);
    boardVal = v; boardCommit = 1'b1; tick = withTick;
    @(negedge clk);
    boardCommit = 1'b0; tick = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 irq after reset", irq, 0);
    check("R1 banks after reset", {bankLo, bankHi}, 8'h01);
    ticks(543);
    check("R1 counter zero after reset", irq, 0);
    ticks(1);
    check("R1 first fire at 544", irq, 1);
    commit(5'b10000, 1'b0);

    // R6-R10: exhaustive bank sweep
    for (int b = 0; b < 32; b++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 16; s++) begin
          int lo, hi;
          string tag;
          @(negedge clk);
          boardVal = 5'(b); prgMode = 2'(m); prgSel = 4'(s);
          #1;
          if ((b & 8) == 0) begin
            lo = 2 * ((b >> 1) & 3); hi = lo + 1; tag = "R6";
          end else if (m == 2) begin
            lo = 8; hi = 8 | (s & 7); tag = "R8";
          end else if (m == 3) begin
            lo = 8 | (s & 7); hi = 15; tag = "R9";
          end else begin
            lo = 8 | (s & 6); hi = lo + 1; tag = "R7";
          end
          check({tag, " bankLo"}, bankLo, lo);
          check({tag, " bankHi"}, bankHi, hi);
          check("R10 chrBank", chrBank, 0);
        end

    // R2-R5: timer sweep over all DIP settings
    for (int d = 0; d < 16; d++) begin
      commit(5'b10000, 1'b0);
      dip = 4'(d);
      n = firstHit(d);
      commit(5'b00000, 1'b0);
      ticks(n - 1);
      check("R3 no fire before threshold", irq, 0);
      ticks(1);
      check("R3 fire at threshold", irq, 1);
      ticks(3);
      check("R4 irq held over ticks", irq, 1);
      repeat (4) @(negedge clk);
      check("R4 irq held idle", irq, 1);
      commit(5'b10001, 1'b0);
      check("R5 ack clears irq", irq, 0);
    end

    // R2: hold by board bit 4 without commit, and idle cycles do not count
    dip = 4'hE;
    n = firstHit(14);
    commit(5'b00000, 1'b0);
    ticks(100);
    @(negedge clk) boardVal = 5'b10000;
    ticks(200);
    @(negedge clk) boardVal = 5'b00000;
    repeat (20) @(negedge clk);
    ticks(n - 101);
    check("R2 held count no fire", irq, 0);
    ticks(1);
    check("R2 held count fires", irq, 1);

    // R5: clear wins over a simultaneous tick, counter restarts
    commit(5'b10000, 1'b0);
    commit(5'b00000, 1'b0);
    ticks(n - 1);
    commit(5'b10000, 1'b1);
    check("R5 clear with tick", irq, 0);
    commit(5'b00000, 1'b0);
    ticks(n - 1);
    check("R5 counter cleared", irq, 0);
    ticks(1);
    check("R5 full count after clear", irq, 1);

    // R1: reset drops a pending irq
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    check("R1 reset clears irq", irq, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule